// File: doc/BRIEF.md
# LRCLK Sample-Rate Detector

This block measures the frame clock of an audio serial port when that clock comes from outside the chip and the port only follows it. A free-running reference clock at 18.432 MHz, one period about 54.25 ns, drives the whole block. The block counts reference periods between successive transitions of the external frame clock. The span it measures is therefore one subframe, which is half a frame-clock period.

The external clock is not related to the reference in any way, so every measurement is approximate to within a cycle or two. The block publishes the raw 12-bit span. It also sorts the span into one of six standard audio rates or marks it as non-standard. A lock flag goes high when two consecutive measurements agree. If the external clock stops, the counter saturates at the top of its range. The block then reports the non-standard class and drops the lock flag.

Top module: `lrclk_rate_detector`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, span_count reads 0, rate_code reads 0 and rate_valid reads 0.
- R2: lrclk_in passes through two synchroniser flops and then an edge detector. A transition first affects the outputs at the third rising reference edge after it, so the outputs are unchanged two reference cycles after the transition.
- R3: span_count takes the number of reference cycles between two successive detected lrclk_in transitions, of either polarity, and is loaded when the second one is detected. The first transition after reset, or after a timeout, only starts a measurement and publishes nothing.
- R4: Between measurement events, span_count, rate_code and rate_valid hold their values.
- R5: If no transition is detected for 4095 reference cycles after the last one, span_count becomes 0xFFF, rate_code becomes 0 and rate_valid becomes 0. The next transition only restarts the measurement.
- R6: rate_code is 1 for a span in 284..292 (32 kHz), 2 for 205..213 (44.1 kHz), 3 for 188..196 (48 kHz), 4 for 100..108 (88.2 kHz), 5 for 92..100 (96 kHz) and 6 for 44..52 (192 kHz). Each window is the nominal span ±4.
- R7: A span that falls in two windows, which happens only at 100, gets the code of the lower rate, 4.
- R8: Any span outside all six windows, 0xFFF included, gives rate_code 0 (non-standard).
- R9: On each published measurement, rate_valid becomes 1 if a previous measurement exists and the two differ by at most 2 counts, and 0 otherwise. The first measurement after reset or after a timeout leaves rate_valid at 0.
- R10: A transition detected in the same cycle the counter reaches 0xFFF counts as a measurement. It publishes 0xFFF, keeps the measurement running, and the next transition publishes a normal span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running 18.432 MHz reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_ref |
| lrclk_in | input | 1 | External frame clock, asynchronous to clk_ref |
| span_count | output | 12 | Reference cycles in the last measured subframe |
| rate_code | output | 3 | Rate class: 0 non-standard, 1..6 standard rates |
| rate_valid | output | 1 | Two consecutive measurements agree within 2 counts |

## Verification
A detected transition and the saturation timeout can fall in the same reference cycle. This happens when the external half-period is exactly 4095 reference cycles. The bench produces it by holding lrclk_in for exactly that many cycles, measured at negative clock edges. It then expects 0xFFF to be published with the run still armed, so the following half-period of 288 cycles must be published as 288. A timeout winning the race would lose that measurement. A separate half-period of 4200 cycles exercises the plain timeout path, where the next transition only restarts counting.

// File: rtl/lrd_pkg.sv
`timescale 1ns/1ps
package lrd_pkg;
   localparam int NUM_RATES = 6;

   typedef enum logic [2:0] {
      RATE_NONSTD = 3'd0,
      RATE_32K    = 3'd1,
      RATE_44K1   = 3'd2,
      RATE_48K    = 3'd3,
      RATE_88K2   = 3'd4,
      RATE_96K    = 3'd5,
      RATE_192K   = 3'd6
   } rate_e;

   // Frame rate in Hz for bin index idx (lowest rate first, also the priority order)
   function automatic int bin_rate_hz(input int idx);
      case (idx)
         0:       return 32000;
         1:       return 44100;
         2:       return 48000;
         3:       return 88200;
         4:       return 96000;
         default: return 192000;
      endcase
   endfunction

   // Rounded reference cycles in one subframe (half a frame period)
   function automatic int bin_nominal(input int ref_hz, input int idx);
      return (ref_hz + bin_rate_hz(idx)) / (2 * bin_rate_hz(idx));
   endfunction
endpackage

// File: rtl/lrd_sync_edge.sv
`timescale 1ns/1ps
module lrd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   // STAGES synchroniser flops plus one history flop for the edge compare
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign edge_o = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/lrd_span_counter.sv
`timescale 1ns/1ps
module lrd_span_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   output logic             pub_o,
   output logic             tmo_o,
   output logic [CNT_W-1:0] span_o,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] SAT = '1;

   logic [CNT_W-1:0] run;
   logic             primed;

   assign span_o = run;
   assign pub_o  = edge_i && primed;
   assign tmo_o  = primed && !edge_i && (run == SAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= '0;
         primed <= 1'b0;
      end else if (edge_i) begin
         run    <= {{(CNT_W-1){1'b0}}, 1'b1};
         primed <= 1'b1;
      end else begin
         if (run != SAT) run <= run + 1'b1;
         if (tmo_o)      primed <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     count_o <= '0;
      else if (pub_o) count_o <= run;
      else if (tmo_o) count_o <= SAT;
   end
endmodule

// File: rtl/lrd_rate_classifier.sv
`timescale 1ns/1ps
module lrd_rate_classifier
   import lrd_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int REF_HZ  = 18432000,
   parameter int BIN_TOL = 4
) (
   input  logic [CNT_W-1:0] count_i,
   output rate_e            code_o
);
   logic [NUM_RATES-1:0] hit;

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_bin
      localparam int NOM = bin_nominal(REF_HZ, i);
      localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - BIN_TOL);
      localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + BIN_TOL);
      assign hit[i] = (count_i >= LO) && (count_i <= HI);
   end

   // Lowest rate wins where windows overlap
   always_comb begin
      code_o = RATE_NONSTD;
      for (int i = NUM_RATES - 1; i >= 0; i--) begin
         if (hit[i]) code_o = rate_e'(3'(i + 1));
      end
   end
endmodule

// File: rtl/lrd_lock_judge.sv
`timescale 1ns/1ps
module lrd_lock_judge #(
   parameter int CNT_W    = 12,
   parameter int LOCK_TOL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pub_i,
   input  logic             tmo_i,
   input  logic [CNT_W-1:0] span_i,
   output logic             valid_o
);
   logic [CNT_W-1:0] prev;
   logic             have_prev;
   logic [CNT_W-1:0] diff;

   assign diff = (span_i > prev) ? (span_i - prev) : (prev - span_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev      <= '0;
         have_prev <= 1'b0;
         valid_o   <= 1'b0;
      end else if (pub_i) begin
         valid_o   <= have_prev && (diff <= CNT_W'(LOCK_TOL));
         prev      <= span_i;
         have_prev <= 1'b1;
      end else if (tmo_i) begin
         valid_o   <= 1'b0;
         have_prev <= 1'b0;
      end
   end
endmodule

// File: rtl/lrclk_rate_detector.sv
`timescale 1ns/1ps
module lrclk_rate_detector
   import lrd_pkg::*;
#(
   parameter int REF_HZ      = 18432000,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter int BIN_TOL     = 4,
   parameter int LOCK_TOL    = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             lrclk_in,
   output logic [CNT_W-1:0] span_count,
   output logic [2:0]       rate_code,
   output logic             rate_valid
);
   localparam int SPAN_MAX = (1 << CNT_W) - 1;
   localparam int TOP_SPAN = bin_nominal(REF_HZ, 0) + BIN_TOL;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TOP_SPAN >= SPAN_MAX) begin : g_bad_width
      $error("CNT_W too narrow for the slowest rate window");
   end
   if (BIN_TOL < 0 || LOCK_TOL < 0) begin : g_bad_tol
      $error("tolerances must be non-negative");
   end

   logic             edge_w;
   logic             pub_w;
   logic             tmo_w;
   logic [CNT_W-1:0] span_w;
   rate_e            code_w;

   lrd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .din    (lrclk_in),
      .edge_o (edge_w)
   );

   lrd_span_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .edge_i  (edge_w),
      .pub_o   (pub_w),
      .tmo_o   (tmo_w),
      .span_o  (span_w),
      .count_o (span_count)
   );

   lrd_rate_classifier #(.CNT_W(CNT_W), .REF_HZ(REF_HZ), .BIN_TOL(BIN_TOL)) u_cls (
      .count_i (span_count),
      .code_o  (code_w)
   );

   lrd_lock_judge #(.CNT_W(CNT_W), .LOCK_TOL(LOCK_TOL)) u_lock (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .pub_i   (pub_w),
      .tmo_i   (tmo_w),
      .span_i  (span_w),
      .valid_o (rate_valid)
   );

   assign rate_code = code_w;
endmodule

// File: rtl/lrd_checker.sv
`timescale 1ns/1ps
module lrd_checker #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pub,
   input logic             tmo,
   input logic [CNT_W-1:0] span_count,
   input logic [2:0]       rate_code,
   input logic             rate_valid
);
   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (span_count == '0 && rate_code == 3'd0 && !rate_valid)); // R1
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(span_count) |-> ($past(pub) || $past(tmo))); // R4
   AST_TMO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> (span_count == '1 && !rate_valid)); // R5
   AST_SAT_NONSTD: assert property (@(posedge clk) disable iff (!rst_n)
      (span_count == '1) |-> (rate_code == 3'd0)); // R8
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rate_code <= 3'd6); // R6
   AST_VALID_ON_PUB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rate_valid) |-> $past(pub)); // R9
   AST_PUB_NOT_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      !(pub && tmo)); // R10
endmodule

bind lrclk_rate_detector lrd_checker #(.CNT_W(CNT_W)) u_lrd_checker (
   .clk        (clk_ref),
   .rst_n      (rst_n),
   .pub        (pub_w),
   .tmo        (tmo_w),
   .span_count (span_count),
   .rate_code  (rate_code),
   .rate_valid (rate_valid)
);

// File: tb/lrclk_rate_detector_bench.sv
`timescale 1ns/1ps
module lrclk_rate_detector_bench;
   localparam int MAXC = 4095;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lr = 1'b0;
   logic [11:0] cnt;
   logic [2:0]  code;
   logic        vld;

   lrclk_rate_detector u_lrclk_rate_detector (
      .clk_ref    (clk),
      .rst_n      (rst_n),
      .lrclk_in   (lr),
      .span_count (cnt),
      .rate_code  (code),
      .rate_valid (vld)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Model state
   int m_cnt = 0;
   int m_prev = 0;
   bit m_vld = 0, m_have = 0, m_primed = 0;
   int last_n = 0;

   function automatic int exp_code(input int c);
      if (c >= 284 && c <= 292) return 1;
      if (c >= 205 && c <= 213) return 2;
      if (c >= 188 && c <= 196) return 3;
      if (c >= 100 && c <= 108) return 4;
      if (c >= 92  && c <= 100) return 5;
      if (c >= 44  && c <= 52)  return 6;
      return 0;
   endfunction

   function automatic int nominal(input int idx);
      case (idx)
         0: return 288;
         1: return 209;
         2: return 192;
         3: return 104;
         4: return 96;
         default: return 48;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic chk_all(input string ctag);
      chk(ctag, "span_count", int'(cnt), m_cnt);
      chk("R6", "rate_code", int'(code), exp_code(m_cnt));
      chk("R9", "rate_valid", int'(vld), int'(m_vld));
   endtask

   task automatic model_edge();
      if (m_primed) begin
         m_vld  = m_have && ((last_n > m_prev ? last_n - m_prev : m_prev - last_n) <= 2);
         m_cnt  = last_n;
         m_prev = last_n;
         m_have = 1'b1;
      end else begin
         m_primed = 1'b1;
      end
   endtask

   // Toggle lrclk now (at a negedge) and hold it for n reference cycles
   task automatic step(input int n, input string ctag);
      int old;
      old = m_cnt;
      lr = ~lr;
      model_edge();
      repeat (2) @(negedge clk);
      chk("R2", "span_count before sync latency", int'(cnt), old);
      @(negedge clk);
      chk_all(ctag);
      if (n > MAXC) begin
         repeat (MAXC + 1) @(negedge clk);
         m_cnt = MAXC; m_vld = 0; m_have = 0; m_primed = 0;
         chk_all("R5");
         repeat (n - MAXC - 5) @(negedge clk);
      end else begin
         repeat (n - 4) @(negedge clk);
      end
      chk("R4", "span_count held", int'(cnt), m_cnt);
      @(negedge clk);
      last_n = n;
   endtask

   initial begin
      #1600000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd2718);
      repeat (5) @(negedge clk);
      chk("R1", "span_count in reset", int'(cnt), 0);
      chk("R1", "rate_code in reset", int'(code), 0);
      chk("R1", "rate_valid in reset", int'(vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "span_count after reset", int'(cnt), 0);

      // Directed corner cases
      step(288,  "R3");   // first edge only primes
      step(289,  "R3");   // publishes 288, 32 kHz, no previous
      step(100,  "R3");   // publishes 289, within 2 -> valid
      step(100,  "R7");   // publishes 100, overlap -> 88.2 kHz
      step(150,  "R9");   // publishes 100, valid
      step(52,   "R8");   // publishes 150, non-standard
      step(53,   "R6");   // publishes 52, 192 kHz edge of window
      step(4095, "R9");   // publishes 53
      step(288,  "R10");  // publishes 4095 on the saturation cycle
      step(4200, "R10");  // publishes 288 (run stayed armed), then times out
      step(209,  "R5");   // edge after timeout only restarts
      step(209,  "R3");   // publishes 209, no previous after timeout
      step(210,  "R9");   // publishes 209, valid

      // Constrained random half-periods
      for (int k = 0; k < 60; k++) begin
         int idx, n;
         idx = int'($urandom % 7);
         if (idx == 6) n = 120 + int'($urandom % 60);
         else          n = nominal(idx) + int'($urandom % 9) - 4;
         step(n, "R3");
         if ($urandom % 2 == 0) step(n + int'($urandom % 3) - 1, "R9");
      end
      step(100, "R3");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule